// File: doc/BRIEF.md
# Operand Shift Unit

This block shifts a 32-bit operand before it reaches the second input of an ALU. It supports five shift kinds: logical left, logical right, arithmetic right, rotate right, and a one-place rotate right through the carry flag. It returns the shifted word together with a carry-out, which the flag logic uses for logical operations. The shift count comes either from a 5-bit field held in the instruction or from the low byte of a register. A select input chooses between the two sources for each operation.

The shift logic itself is combinational. Its result, carry-out and a valid flag are captured in one output register stage, so the answer appears one clock after the request. When no request is present, the last result and carry-out stay unchanged.

Top module: `shift_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `res_valid`, `res_data` and `carry_out` are all cleared to 0 by that edge.
- R2: `res_valid` equals `in_valid` from one clock earlier. On a cycle with `in_valid` low, `res_data` and `carry_out` keep their previous values.
- R3: The `kind` field is encoded as follows: 0 = logical left, 1 = logical right, 2 = arithmetic right, 3 = rotate right, 4 = rotate through carry. Codes 5 to 7 return the operand unchanged, with `carry_out` equal to `carry_in`.
- R4: For kinds 0 to 3, a shift count of 0 returns the operand unchanged, with `carry_out` equal to `carry_in`.
- R5: A logical left shift by n (1 to 32) fills the low n bits with zeros. `carry_out` is operand bit 32-n.
- R6: A logical right shift by n (1 to 32) fills the high n bits with zeros. `carry_out` is operand bit n-1.
- R7: An arithmetic right shift by n (1 to 31) fills the high n bits with operand bit 31. `carry_out` is operand bit n-1.
- R8: A rotate right by n, where n is not a multiple of 32, moves bit i to position (i - n) mod 32. `carry_out` is the new bit 31.
- R9: A rotate right by a nonzero multiple of 32 (32, 64, ... 224) returns the operand unchanged, with `carry_out` equal to operand bit 31.
- R10: A rotate through carry returns {`carry_in`, operand[31:1]}, with `carry_out` equal to operand bit 0.
- R11: A logical left or logical right shift by more than 32 gives 0, with `carry_out` 0.
- R12: An arithmetic right shift by 32 or more gives 32 copies of operand bit 31, with `carry_out` equal to operand bit 31.
- R13: When `amt_is_reg` is 1, the count is `reg_amt` (0 to 255). When it is 0, the count is `imm_amt` (0 to 31).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| op_data | input | 32 | Operand to shift |
| carry_in | input | 1 | Current carry flag |
| kind | input | 3 | Shift kind code |
| amt_is_reg | input | 1 | Count source select: 1 = register byte, 0 = immediate |
| imm_amt | input | 5 | Immediate shift count |
| reg_amt | input | 8 | Low byte of the count register |
| res_valid | output | 1 | Result present |
| res_data | output | 32 | Shifted operand |
| carry_out | output | 1 | Shifter carry-out |

## Verification
There is only one register stage, so any error in the shift or carry selection appears on `res_data` or `carry_out` in the very next cycle. Because of this, the reference model is compared on every request at that cycle. The reference model performs single-bit steps repeated n times, so the fill rules, the last-bit carry and the range rules above 32 all follow from one simple loop rather than from case tables. The count values most likely to hide a bad carry index or a bad range boundary are tested directly: 0, 1, 31, 32, 33, 64 and 255. Cycles with no request check that an unchanging output register really holds its value.

// File: rtl/shift_pkg.sv
package shift_pkg;
  typedef enum logic [2:0] {
    SK_LSL = 3'd0,
    SK_LSR = 3'd1,
    SK_ASR = 3'd2,
    SK_ROR = 3'd3,
    SK_RRX = 3'd4
  } shift_kind_e;
endpackage

// File: rtl/shift_amount_sel.sv
module shift_amount_sel #(
  parameter int IMM_W = 5,
  parameter int AMT_W = 8
) (
  input  logic             use_reg,
  input  logic [IMM_W-1:0] imm_amt,
  input  logic [AMT_W-1:0] reg_amt,
  output logic [AMT_W-1:0] amount
);
  logic [AMT_W-1:0] imm_ext;

  generate
    if (AMT_W > IMM_W) begin : g_pad
      assign imm_ext = {{(AMT_W-IMM_W){1'b0}}, imm_amt};
    end else begin : g_same
      assign imm_ext = imm_amt[AMT_W-1:0];
    end
  endgenerate

  assign amount = use_reg ? reg_amt : imm_ext;
endmodule

// File: rtl/shift_core.sv
module shift_core
  import shift_pkg::*;
#(
  parameter int W     = 32,
  parameter int AMT_W = 8
) (
  input  logic [W-1:0]     op,
  input  logic             cin,
  input  logic [2:0]       kind,
  input  logic [AMT_W-1:0] n,
  output logic [W-1:0]     res,
  output logic             cout
);
  localparam int IW = $clog2(W);

  logic             zero_n;
  logic             over_w;
  logic             at_least_w;
  logic [IW-1:0]    rot_n;
  logic [IW-1:0]    lo_idx;
  logic [IW-1:0]    hi_idx;
  logic [W-1:0]     rot_res;

  assign zero_n     = (n == '0);
  assign over_w     = (n > AMT_W'(W));
  assign at_least_w = (n >= AMT_W'(W));
  assign rot_n      = n[IW-1:0];
  assign lo_idx     = IW'(n - 1'b1);
  assign hi_idx     = IW'(AMT_W'(W) - n);
  assign rot_res    = (op >> rot_n) | (op << (W - int'(rot_n)));

  always_comb begin
    res  = op;
    cout = cin;
    case (shift_kind_e'(kind))
      SK_LSL: if (!zero_n) begin
        if (over_w) begin
          res  = '0;
          cout = 1'b0;
        end else begin
          res  = op << n;
          cout = op[hi_idx];
        end
      end
      SK_LSR: if (!zero_n) begin
        if (over_w) begin
          res  = '0;
          cout = 1'b0;
        end else begin
          res  = op >> n;
          cout = op[lo_idx];
        end
      end
      SK_ASR: if (!zero_n) begin
        if (at_least_w) begin
          res  = {W{op[W-1]}};
          cout = op[W-1];
        end else begin
          res  = W'($signed(op) >>> n);
          cout = op[lo_idx];
        end
      end
      SK_ROR: if (!zero_n) begin
        res  = rot_res;
        cout = rot_res[W-1];
      end
      SK_RRX: begin
        res  = {cin, op[W-1:1]};
        cout = op[0];
      end
      default: begin
        res  = op;
        cout = cin;
      end
    endcase
  end
endmodule

// File: rtl/shift_unit.sv
module shift_unit
  import shift_pkg::*;
#(
  parameter int W     = 32,
  parameter int IMM_W = 5,
  parameter int AMT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [W-1:0]     op_data,
  input  logic             carry_in,
  input  logic [2:0]       kind,
  input  logic             amt_is_reg,
  input  logic [IMM_W-1:0] imm_amt,
  input  logic [AMT_W-1:0] reg_amt,
  output logic             res_valid,
  output logic [W-1:0]     res_data,
  output logic             carry_out
);
  logic [AMT_W-1:0] amount;
  logic [W-1:0]     sh_res;
  logic             sh_cout;

  shift_amount_sel #(.IMM_W(IMM_W), .AMT_W(AMT_W)) u_amt (
    .use_reg (amt_is_reg),
    .imm_amt (imm_amt),
    .reg_amt (reg_amt),
    .amount  (amount)
  );

  shift_core #(.W(W), .AMT_W(AMT_W)) u_core (
    .op   (op_data),
    .cin  (carry_in),
    .kind (kind),
    .n    (amount),
    .res  (sh_res),
    .cout (sh_cout)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_data  <= '0;
      carry_out <= 1'b0;
    end else begin
      res_valid <= in_valid;
      if (in_valid) begin
        res_data  <= sh_res;
        carry_out <= sh_cout;
      end
    end
  end

  // R2
  valid_lag_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> res_valid);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(res_data) && $stable(carry_out)));

  // R10
  rrx_path_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && kind == 3'd4) |=>
      (res_data == {$past(carry_in), $past(op_data[W-1:1])} && carry_out == $past(op_data[0])));

  // R4
  zero_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && kind < 3'd4 && !amt_is_reg && imm_amt == '0) |=>
      (res_data == $past(op_data) && carry_out == $past(carry_in)));

  // R11
  logic_over_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && kind < 3'd2 && amt_is_reg && reg_amt > AMT_W'(W)) |=>
      (res_data == '0 && !carry_out));

  // R12
  asr_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && kind == 3'd2 && amt_is_reg && reg_amt >= AMT_W'(W)) |=>
      (res_data == {W{$past(op_data[W-1])}} && carry_out == $past(op_data[W-1])));

  // R9
  ror_full_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && kind == 3'd3 && amt_is_reg && reg_amt != '0 && reg_amt[4:0] == 5'd0) |=>
      (res_data == $past(op_data) && carry_out == $past(op_data[W-1])));
endmodule

// File: tb/sim_shift_unit.sv
module sim_shift_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] op_data = '0;
  logic        carry_in = 1'b0;
  logic [2:0]  kind = '0;
  logic        amt_is_reg = 1'b0;
  logic [4:0]  imm_amt = '0;
  logic [7:0]  reg_amt = '0;
  logic        res_valid;
  logic [31:0] res_data;
  logic        carry_out;

  int tests = 0;
  int fails = 0;
  logic [31:0] last_res = '0;
  logic        last_c = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shift_unit u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_data(op_data),
    .carry_in(carry_in), .kind(kind), .amt_is_reg(amt_is_reg),
    .imm_amt(imm_amt), .reg_amt(reg_amt), .res_valid(res_valid),
    .res_data(res_data), .carry_out(carry_out)
  );

  // Behavioural reference: n single-bit steps.
  function automatic logic [32:0] ref_shift(input logic [2:0] k, input logic [31:0] v,
                                            input logic c, input int n);
    logic [31:0] x = v;
    logic        cc = c;
    if (k == 3'd4) return {x[0], c, x[31:1]};
    if (k > 3'd4) return {c, v};
    for (int s = 0; s < n; s++) begin
      case (k)
        3'd0: begin cc = x[31]; x = {x[30:0], 1'b0}; end
        3'd1: begin cc = x[0];  x = {1'b0, x[31:1]}; end
        3'd2: begin cc = x[0];  x = {x[31], x[31:1]}; end
        default: begin cc = x[0]; x = {x[0], x[31:1]}; end
      endcase
    end
    return {cc, x};
  endfunction

  task automatic run(input string tag, input logic [2:0] k, input logic [31:0] v,
                     input logic c, input logic use_reg, input int amt);
    logic [32:0] e;
    int n;
    @(negedge clk);
    in_valid = 1'b1; op_data = v; carry_in = c; kind = k; amt_is_reg = use_reg;
    if (use_reg) begin
      reg_amt = 8'(amt); imm_amt = 5'(~amt);
      n = amt & 255;
    end else begin
      imm_amt = 5'(amt); reg_amt = 8'(~amt);
      n = amt & 31;
    end
    e = ref_shift(k, v, c, n);
    @(negedge clk);
    in_valid = 1'b0;
    tests++;
    if (res_valid !== 1'b1 || res_data !== e[31:0] || carry_out !== e[32]) begin
      fails++;
      $display("FAIL %s: kind=%0d n=%0d op=%h got v=%b d=%h c=%b exp v=1 d=%h c=%b",
               tag, k, n, v, res_valid, res_data, carry_out, e[31:0], e[32]);
    end
    last_res = e[31:0];
    last_c = e[32];
  endtask

  task automatic idle_check(input string tag);
    @(negedge clk);
    op_data = ~op_data; carry_in = ~carry_in;
    @(negedge clk);
    tests++;
    if (res_valid !== 1'b0 || res_data !== last_res || carry_out !== last_c) begin
      fails++;
      $display("FAIL %s: idle got v=%b d=%h c=%b exp v=0 d=%h c=%b",
               tag, res_valid, res_data, carry_out, last_res, last_c);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete, got hang exp finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    int amts[7] = '{0, 1, 31, 32, 33, 64, 255};
    repeat (3) @(posedge clk);
    @(negedge clk);
    tests++;
    if (res_valid !== 1'b0 || res_data !== 32'h0 || carry_out !== 1'b0) begin
      fails++;
      $display("FAIL R1: got v=%b d=%h c=%b exp 0 0 0", res_valid, res_data, carry_out);
    end
    rst = 1'b0;

    // R4 R5 R6 R7 R8 R9 R11 R12 R13: edge counts from the register byte
    for (int k = 0; k < 4; k++)
      for (int a = 0; a < 7; a++) begin
        run("R5_R6_R7_R8_R9_R11_R12_R13", 3'(k), 32'hC000_0001, 1'b1, 1'b1, amts[a]);
        run("R4_R5_R6_R7_R8_R9_R11_R12", 3'(k), 32'h7FFF_FFFE, 1'b0, 1'b1, amts[a]);
      end
    // R4 zero count via immediate, both carry values
    run("R4", 3'd1, 32'hDEAD_BEEF, 1'b1, 1'b0, 0);
    run("R4", 3'd2, 32'h8000_0000, 1'b0, 1'b0, 0);
    // R10 rotate through carry
    run("R10", 3'd4, 32'h0000_0001, 1'b1, 1'b0, 7);
    run("R10", 3'd4, 32'hFFFF_FFFE, 1'b0, 1'b1, 0);
    // R3 unused codes pass through
    for (int k = 5; k < 8; k++) run("R3", 3'(k), 32'h1234_5678, 1'b1, 1'b1, 9);
    // R2 hold while idle
    idle_check("R2");
    run("R13", 3'd0, 32'h0000_00FF, 1'b0, 1'b0, 31);
    idle_check("R2");
    // R8 R13 pseudo-random mix over both count sources
    for (int i = 0; i < 400; i++)
      run("R8_R13_mix", 3'($urandom_range(0, 7)), $urandom, 1'($urandom),
          1'($urandom), $urandom_range(0, 255));

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule